// File: doc/BRIEF.md
# Data-dependent early-exit loop controller

This block sequences an element operation across indices 0 up to a vector length minus one. It handles one element result per step and applies a selectable condition to each result. The first element whose condition holds ends the loop. The length is then rewritten to that element's index, so the failing element and every later one are never committed. An element-level fault input counts as a condition hit, so a faulting memory element shortens the vector and raises no exception.

The element operation sits outside the block. The controller presents an index on `req_idx` with `req_valid`, then waits for `res_valid` with the result data and fault flag. While it waits, the index is held. A surviving element is committed in the same cycle its result arrives. When the loop ends, `done` pulses for one cycle, and `vl_out` carries the final length until the next accepted start.

Top module: `elx_loop`

## Requirements
- R1: After reset, `done`, `req_valid` and `commit_we` are 0 and `vl_out` is 0.
- R2: After an accepted start with a nonzero length, element indices are requested in ascending order from 0, one index per accepted result. `req_idx` stays constant while `res_valid` is low.
- R3: In the cycle a result arrives for an element whose condition is false and whose fault flag is clear, `commit_we` is 1 and `commit_idx` equals that element's index. At all other times `commit_we` is 0.
- R4: `test_sel` is captured at start. Its codes are: 2'b00 hits when the result is zero, 2'b01 when it is nonzero, 2'b10 when its most significant bit is 1, and 2'b11 when that bit is 0.
- R5: When element i hits, that element is not committed. No index beyond i is requested, and `vl_out` becomes i.
- R6: A result presented with `res_fault`=1 is treated as a hit whatever its data.
- R7: If no element hits, every index below the initial length is committed and `vl_out` equals the initial length.
- R8: A start with length 0 gives `done` in the cycle after start, makes no requests, and leaves `vl_out` at 0.
- R9: `done` is high for exactly one cycle, in the cycle after the result that ends the loop. `vl_out` keeps its value until the next start.
- R10: A start pulse received while a loop is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a loop (taken only when idle) |
| vl_in | input | VLW | Initial vector length |
| test_sel | input | 2 | Exit condition code |
| req_valid | output | 1 | An element index is being requested |
| req_idx | output | VLW | Requested element index |
| res_valid | input | 1 | Result for `req_idx` is present |
| res_data | input | DW | Element result |
| res_fault | input | 1 | Element faulted |
| commit_we | output | 1 | Commit the current element |
| commit_idx | output | VLW | Index being committed |
| vl_out | output | VLW | Final vector length |
| done | output | 1 | Loop complete (one-cycle pulse) |

## Verification
A corrupted index counter appears at once on `req_idx`, in the first request that follows, as a skipped or repeated element. A wrong latched condition or an inverted hit decision appears in the same cycle as a spurious or missing `commit_we`. A length register that is overwritten at the wrong time shows as a wrong `vl_out` in the cycle `done` rises, or later as drift while idle. A sequencer that stays in or leaves its terminal state wrongly makes `done` last more or less than one cycle, or arrive off the cycle after the terminal result.

// File: rtl/elx_pkg.sv
package elx_pkg;
   typedef enum logic [1:0] {
      TST_ZERO    = 2'b00,
      TST_NONZERO = 2'b01,
      TST_NEG     = 2'b10,
      TST_NONNEG  = 2'b11
   } tst_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_RUN  = 2'b01,
      ST_FIN  = 2'b10
   } st_e;
endpackage

// File: rtl/elx_test.sv
module elx_test #(
   parameter int DW       = 16,
   parameter bit FAULT_EN = 1'b1
) (
   input  logic [1:0]    sel,
   input  logic [DW-1:0] data,
   input  logic          fault,
   output logic          hit
);
   import elx_pkg::*;

   initial begin
      if (DW < 2) $fatal(1, "elx_test: DW must be at least 2");
   end

   logic cond;

   always_comb begin
      unique case (tst_e'(sel))
         TST_ZERO:    cond = (data == '0);
         TST_NONZERO: cond = (data != '0);
         TST_NEG:     cond = data[DW-1];
         default:     cond = ~data[DW-1];
      endcase
   end

   generate
      if (FAULT_EN) begin : g_fault
         assign hit = cond | fault;
      end else begin : g_nofault
         assign hit = cond;
      end
   endgenerate
endmodule

// File: rtl/elx_seq.sv
module elx_seq #(
   parameter int VLW = 6
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [VLW-1:0] vl_in,
   input  logic [1:0]     sel_in,
   input  logic           res_valid,
   input  logic           hit,
   output logic [1:0]     sel_q,
   output logic           req_valid,
   output logic [VLW-1:0] req_idx,
   output logic           commit_we,
   output logic [VLW-1:0] commit_idx,
   output logic [VLW-1:0] vl_out,
   output logic           done
);
   import elx_pkg::*;

   localparam int CW = VLW + 1;

   initial begin
      if (VLW < 1) $fatal(1, "elx_seq: VLW must be at least 1");
   end

   st_e            st;
   logic [VLW-1:0] idx;
   logic [VLW-1:0] vl_q;
   logic           last;

   assign last = ({1'b0, idx} + CW'(1)) == {1'b0, vl_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         idx   <= '0;
         vl_q  <= '0;
         sel_q <= '0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (start) begin
                  vl_q  <= vl_in;
                  sel_q <= sel_in;
                  idx   <= '0;
                  st    <= (vl_in == '0) ? ST_FIN : ST_RUN;
               end
            end
            ST_RUN: begin
               if (res_valid) begin
                  if (hit) begin
                     vl_q <= idx;
                     st   <= ST_FIN;
                  end else if (last) begin
                     st <= ST_FIN;
                  end else begin
                     idx <= idx + 1'b1;
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign req_valid  = (st == ST_RUN);
   assign req_idx    = idx;
   assign commit_we  = (st == ST_RUN) && res_valid && !hit;
   assign commit_idx = idx;
   assign vl_out     = vl_q;
   assign done       = (st == ST_FIN);

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R9
   vl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && !start) |=> $stable(vl_out));
   // R2
   idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !res_valid) |=> (req_valid && $stable(req_idx)));
   // R5
   shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && res_valid && hit) |=> (done && vl_out == $past(req_idx)));
   // R8
   empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && start && vl_in == '0) |=> (done && !req_valid));
   // R10
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !res_valid) |=> $stable(vl_out));
endmodule

// File: rtl/elx_loop.sv
module elx_loop #(
   parameter int VLW      = 6,
   parameter int DW       = 16,
   parameter bit FAULT_EN = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [VLW-1:0] vl_in,
   input  logic [1:0]     test_sel,
   output logic           req_valid,
   output logic [VLW-1:0] req_idx,
   input  logic           res_valid,
   input  logic [DW-1:0]  res_data,
   input  logic           res_fault,
   output logic           commit_we,
   output logic [VLW-1:0] commit_idx,
   output logic [VLW-1:0] vl_out,
   output logic           done
);
   logic [1:0] sel_q;
   logic       hit;

   elx_test #(.DW(DW), .FAULT_EN(FAULT_EN)) u_test (
      .sel   (sel_q),
      .data  (res_data),
      .fault (res_fault),
      .hit   (hit)
   );

   elx_seq #(.VLW(VLW)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .vl_in      (vl_in),
      .sel_in     (test_sel),
      .res_valid  (res_valid),
      .hit        (hit),
      .sel_q      (sel_q),
      .req_valid  (req_valid),
      .req_idx    (req_idx),
      .commit_we  (commit_we),
      .commit_idx (commit_idx),
      .vl_out     (vl_out),
      .done       (done)
   );

   // R6
   fault_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && res_valid && res_fault && FAULT_EN) |-> !commit_we);
   // R3
   commit_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_we |-> (req_valid && res_valid && commit_idx == req_idx));
endmodule

// File: tb/elx_loop_tb.sv
module elx_loop_tb;
   localparam int CLK_PERIOD = 10;
   localparam int VLW = 6;
   localparam int DW  = 16;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic [VLW-1:0] vl_in = '0;
   logic [1:0]     test_sel = '0;
   logic           req_valid;
   logic [VLW-1:0] req_idx;
   logic           res_valid = 1'b0;
   logic [DW-1:0]  res_data = '0;
   logic           res_fault = 1'b0;
   logic           commit_we;
   logic [VLW-1:0] commit_idx;
   logic [VLW-1:0] vl_out;
   logic           done;

   int checks = 0;
   int bad = 0;
   logic [DW-1:0] data_mem [64];
   logic          fault_mem [64];

   always #(CLK_PERIOD/2) clk = ~clk;

   elx_loop #(.VLW(VLW), .DW(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vl_in),
      .test_sel(test_sel), .req_valid(req_valid), .req_idx(req_idx),
      .res_valid(res_valid), .res_data(res_data), .res_fault(res_fault),
      .commit_we(commit_we), .commit_idx(commit_idx), .vl_out(vl_out),
      .done(done)
   );

   task automatic chk(input string rq, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
      end
   endtask

   function automatic bit model_hit(input logic [1:0] sel, input logic [DW-1:0] d, input logic f);
      bit c;
      case (sel)
         2'b00: c = (d == '0);
         2'b01: c = (d != '0);
         2'b10: c = d[DW-1];
         default: c = !d[DW-1];
      endcase
      return c | f;
   endfunction

   task automatic fill(input logic [DW-1:0] v);
      for (int i = 0; i < 64; i++) begin
         data_mem[i] = v;
         fault_mem[i] = 1'b0;
      end
   endtask

   task automatic run_case(input string rq, input int vl, input logic [1:0] sel,
                           input bit stall, input bit poke);
      int exp_vl = vl;
      int nxt = 0;
      int ncommit = 0;
      bit term = 0;
      bit fin = 0;
      bit h;
      for (int i = 0; i < vl; i++)
         if (exp_vl == vl && model_hit(sel, data_mem[i], fault_mem[i])) exp_vl = i;
      @(negedge clk);
      start = 1'b1; vl_in = VLW'(vl); test_sel = sel;
      @(negedge clk);
      start = 1'b0; vl_in = '0; test_sel = ~sel;
      if (vl == 0) term = 1;
      for (int cyc = 0; cyc < 400 && !fin; cyc++) begin
         if (cyc > 0) @(negedge clk);
         start = 1'b0;
         if (term) begin
            res_valid = 1'b0;
            chk("R9", "done after terminal result", int'(done), 1);
            chk(rq, "final vl", int'(vl_out), exp_vl);
            chk("R5", "no request at done", int'(req_valid), 0);
            fin = 1;
         end else if (done) begin
            chk("R9", "premature done", 1, 0);
            fin = 1;
         end else if (req_valid) begin
            chk("R2", "requested index", int'(req_idx), nxt);
            if (poke && cyc == 0) begin
               start = 1'b1; vl_in = VLW'(1);
            end
            if (stall && (cyc % 2 == 0)) begin
               res_valid = 1'b0;
               #1;
               chk("R3", "no commit while stalled", int'(commit_we), 0);
            end else begin
               res_valid = 1'b1;
               res_data  = data_mem[nxt];
               res_fault = fault_mem[nxt];
               h = model_hit(sel, data_mem[nxt], fault_mem[nxt]);
               #1;
               if (int'(commit_we) != int'(!h))
                  chk(h ? "R5" : "R3", "commit enable", int'(commit_we), int'(!h));
               if (commit_we) begin
                  ncommit++;
                  if (int'(commit_idx) != nxt) chk("R3", "commit index", int'(commit_idx), nxt);
               end
               if (h || nxt == vl - 1) term = 1;
               nxt++;
            end
         end else begin
            res_valid = 1'b0;
            if (vl != 0) chk("R2", "request expected", 0, 1);
         end
      end
      res_valid = 1'b0; res_fault = 1'b0; start = 1'b0;
      chk(rq, "loop finished", int'(fin), 1);
      chk(exp_vl == vl ? "R7" : "R5", "commit count", ncommit, exp_vl);
      @(negedge clk);
      chk("R9", "done one cycle", int'(done), 0);
      @(negedge clk);
      @(negedge clk);
      chk("R9", "vl held", int'(vl_out), exp_vl);
   endtask

   task automatic t_reset();
      #1;
      chk("R1", "done at reset", int'(done), 0);
      chk("R1", "req at reset", int'(req_valid), 0);
      chk("R1", "commit at reset", int'(commit_we), 0);
      chk("R1", "vl at reset", int'(vl_out), 0);
   endtask

   task automatic t_all_pass();
      fill(16'h0005);
      run_case("R7", 5, 2'b00, 0, 0);
   endtask

   task automatic t_zero_hit();
      fill(16'h0011);
      data_mem[3] = '0;
      run_case("R4", 8, 2'b00, 0, 0);
   endtask

   task automatic t_nonzero_first();
      fill(16'h0000);
      data_mem[0] = 16'h0100;
      run_case("R4", 6, 2'b01, 0, 0);
   endtask

   task automatic t_neg_stall();
      fill(16'h7fff);
      data_mem[6] = 16'h8000;
      data_mem[8] = 16'hffff;
      run_case("R4", 10, 2'b10, 1, 0);
   endtask

   task automatic t_nonneg_last();
      fill(16'hc000);
      data_mem[6] = 16'h0000;
      run_case("R4", 7, 2'b11, 0, 0);
   endtask

   task automatic t_fault();
      fill(16'h0003);
      fault_mem[2] = 1'b1;
      run_case("R6", 9, 2'b00, 0, 0);
   endtask

   task automatic t_empty();
      fill(16'h0000);
      run_case("R8", 0, 2'b00, 0, 0);
   endtask

   task automatic t_busy_start();
      fill(16'h0002);
      run_case("R10", 4, 2'b00, 0, 1);
   endtask

   task automatic t_full();
      fill(16'h1234);
      run_case("R7", 63, 2'b10, 0, 0);
   endtask

   initial begin
      for (int i = 0; i < 200000; i++) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_all_pass();
      t_zero_hit();
      t_nonzero_first();
      t_neg_stall();
      t_nonneg_last();
      t_fault();
      t_empty();
      t_busy_start();
      t_full();
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule